// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous static RAM whose shared data bus never needs an idle cycle when it changes direction. On every rising clock edge it samples chip enable, write enable and address. Each accepted command owns one later bus cycle, called its data slot. A read returns its word during that slot. A write takes its word from `din` during that slot and stores it on the edge that closes the slot. Read slots and write slots sit at the same distance from their command edges, so any mix of reads and writes can be issued on consecutive edges.

The parameter `PIPELINED` picks one of two read paths. With `PIPELINED = 0` (flow-through), the data slot is the cycle right after the command edge, and the read word comes straight from the array. With `PIPELINED = 1` (pipelined), the slot is one cycle later, because a register holds the read word. Commands wait in a short delay line of one or two stages. The oldest stage is the slot state. It takes one of three states: SLOT_IDLE, SLOT_READ or SLOT_WRITE. On each edge the next state follows the command captured on that edge: ce=1,we=0 moves to SLOT_READ, ce=1,we=1 moves to SLOT_WRITE, and ce=0 moves to SLOT_IDLE. Any state can move to any state. In pipelined mode, a read whose address matches the write being stored on the same edge takes the incoming `din` rather than the old array word.

Top module: `noturn_sram`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `oe` is low and no command is pending.
- R2: In pipelined mode, a read command sampled at edge k drives its word on `dout` with `oe` high in the cycle between edges k+1 and k+2.
- R3: A write command sampled at edge k takes `din` from its data slot (the cycle before edge k+1 in flow-through mode, the cycle before edge k+2 in pipelined mode). Later reads of that address return the word.
- R4: Reads and writes in any order may be issued on consecutive edges with no idle cycles between them, and every read returns the most recent earlier write to its address in command order.
- R5: A read issued on the edge right after a write to the same address returns the new word. This applies in both modes.
- R6: `oe` is high only in read slots. It is low in write slots.
- R7: A cycle with `ce` low is a no-op whatever `we`, `addr` and `din` hold. It changes no stored word, and its slot is idle with `oe` low.
- R8: `din` has no effect outside write slots.
- R9: With `PIPELINED = 0`, a read sampled at edge k drives its word with `oe` high in the cycle between edges k and k+1. Read latency is one cycle shorter than in pipelined mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Commands are sampled on the rising edge. |
| rst_n | input | 1 | Active-low synchronous reset. Clears pending commands and the read register. |
| ce | input | 1 | Chip enable. When low, the cycle is a no-op. |
| we | input | 1 | Command type: 1 is a write, 0 is a read. |
| addr | input | ADDR_W | Word address. |
| din | input | DATA_W | Write word, taken during write slots only. |
| dout | output | DATA_W | Read word. Zero when `oe` is low. |
| oe | output | 1 | High while read data is on the bus. |

## Verification
In pipelined mode, two things can fall on the same clock edge: a write stores its word, and a later read samples the array. If that read targets the same address, it must take the bypassed `din` rather than the stale array word. The bench provokes this by issuing write-then-read pairs to each address on back-to-back edges, and by mixing such pairs into a long pseudo-random stream. Each read is judged against a reference memory that the bench updates in command order. Both build variants run side by side on the same commands, and each one receives its write data in its own slot.

// File: rtl/noturn_sram_pkg.sv
package noturn_sram_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/noturn_cmd_pipe.sv
module noturn_cmd_pipe
    import noturn_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output slot_kind_e        head_kind,
    output logic [ADDR_W-1:0] head_addr,
    output slot_kind_e        tail_kind,
    output logic [ADDR_W-1:0] tail_addr
);

    slot_kind_e        kind_q [LAT];
    logic [ADDR_W-1:0] addr_q [LAT];
    slot_kind_e        kind_next;

    // Next slot state from the command on the bus
    always_comb begin
        unique case ({ce, we})
            2'b11:   kind_next = SLOT_WRITE;
            2'b10:   kind_next = SLOT_READ;
            default: kind_next = SLOT_IDLE;
        endcase
    end

    // State register: delay line of pending commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                kind_q[i] <= SLOT_IDLE;
                addr_q[i] <= '0;
            end
        end else begin
            kind_q[0] <= kind_next;
            addr_q[0] <= addr;
            for (int i = 1; i < LAT; i++) begin
                kind_q[i] <= kind_q[i-1];
                addr_q[i] <= addr_q[i-1];
            end
        end
    end

    assign head_kind = kind_q[0];
    assign head_addr = addr_q[0];
    assign tail_kind = kind_q[LAT-1];
    assign tail_addr = addr_q[LAT-1];

endmodule

// File: rtl/noturn_store.sv
module noturn_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/noturn_read_path.sv
module noturn_read_path
    import noturn_sram_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter bit PIPELINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_kind_e        head_kind,
    input  logic [ADDR_W-1:0] head_addr,
    input  slot_kind_e        tail_kind,
    input  logic [ADDR_W-1:0] tail_addr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_word
);

    generate
        if (PIPELINED) begin : g_piped
            logic [DATA_W-1:0] rd_q;
            logic              bypass_hit;

            // Write stored on this edge to the address being read
            assign bypass_hit = (tail_kind == SLOT_WRITE) && (tail_addr == head_addr);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_q <= '0;
                end else if (head_kind == SLOT_READ) begin
                    rd_q <= bypass_hit ? din : arr_data;
                end
            end

            assign rd_word = rd_q;
        end else begin : g_flow
            logic unused_flow;
            assign unused_flow = ^{clk, rst_n, head_kind, head_addr, tail_kind, tail_addr, din};
            assign rd_word     = arr_data;
        end
    endgenerate

endmodule

// File: rtl/noturn_sram.sv
module noturn_sram
    import noturn_sram_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter bit PIPELINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    localparam int LAT = PIPELINED ? 2 : 1;

    slot_kind_e        head_kind;
    slot_kind_e        tail_kind;
    logic [ADDR_W-1:0] head_addr;
    logic [ADDR_W-1:0] tail_addr;
    logic [DATA_W-1:0] arr_data;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;
    logic              oe_int;

    noturn_cmd_pipe #(
        .ADDR_W (ADDR_W),
        .LAT    (LAT)
    ) i_cmd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .we        (we),
        .addr      (addr),
        .head_kind (head_kind),
        .head_addr (head_addr),
        .tail_kind (tail_kind),
        .tail_addr (tail_addr)
    );

    noturn_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (tail_addr),
        .wr_data (din),
        .rd_addr (head_addr),
        .rd_data (arr_data)
    );

    noturn_read_path #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PIPELINED (PIPELINED)
    ) i_read_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_kind (head_kind),
        .head_addr (head_addr),
        .tail_kind (tail_kind),
        .tail_addr (tail_addr),
        .din       (din),
        .arr_data  (arr_data),
        .rd_word   (rd_word)
    );

    // Output decode from the slot state
    always_comb begin
        oe_int = 1'b0;
        wr_en  = 1'b0;
        unique case (tail_kind)
            SLOT_READ:  oe_int = 1'b1;
            SLOT_WRITE: wr_en  = 1'b1;
            SLOT_IDLE:  ;
            default:    ;
        endcase
    end

    assign oe   = oe_int;
    assign dout = oe_int ? rd_word : '0;

endmodule

// File: rtl/noturn_sram_chk.sv
module noturn_sram_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter bit PIPELINED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              oe
);

    logic [1:0]        h_rd;
    logic [1:0]        h_wr;
    logic [ADDR_W-1:0] h_a0;
    logic [ADDR_W-1:0] h_a1;
    logic              prev_wr;
    logic [ADDR_W-1:0] prev_a;
    logic [DATA_W-1:0] prev_din;
    logic              cur_rd;
    logic              cur_wr;
    logic [ADDR_W-1:0] cur_a;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rd     <= '0;
            h_wr     <= '0;
            h_a0     <= '0;
            h_a1     <= '0;
            prev_wr  <= 1'b0;
            prev_a   <= '0;
            prev_din <= '0;
        end else begin
            h_rd     <= {h_rd[0], ce && !we};
            h_wr     <= {h_wr[0], ce && we};
            h_a0     <= addr;
            h_a1     <= h_a0;
            prev_wr  <= cur_wr;
            prev_a   <= cur_a;
            prev_din <= din;
        end
    end

    assign cur_rd = PIPELINED ? h_rd[1] : h_rd[0];
    assign cur_wr = PIPELINED ? h_wr[1] : h_wr[0];
    assign cur_a  = PIPELINED ? h_a1 : h_a0;

    AST_OE_IN_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_rd |-> oe); // R2

    AST_OE_OFF_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |-> !oe); // R6

    AST_OE_OFF_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_rd && !cur_wr) |-> !oe); // R7

    AST_BYPASS_NEW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_rd && prev_wr && (cur_a == prev_a)) |-> (dout == prev_din)); // R5

endmodule

bind noturn_sram noturn_sram_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PIPELINED (PIPELINED)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .we    (we),
    .addr  (addr),
    .din   (din),
    .dout  (dout),
    .oe    (oe)
);

// File: tb/test_noturn_sram.sv
module test_noturn_sram;

    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam int NA   = 1 << AW;
    localparam int NMAX = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din_p = '0;
    logic [DW-1:0] din_f = '0;
    logic [DW-1:0] dout_p;
    logic [DW-1:0] dout_f;
    logic          oe_p;
    logic          oe_f;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int ncmd = 0;

    logic          c_ce [NMAX];
    logic          c_we [NMAX];
    logic [AW-1:0] c_a  [NMAX];
    logic [DW-1:0] c_wd [NMAX];
    logic [DW-1:0] c_ex [NMAX];
    string         c_tag [NMAX];
    logic [DW-1:0] model [NA];

    always #4 clk = ~clk;

    noturn_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1)) i_noturn_sram (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .din(din_p), .dout(dout_p), .oe(oe_p)
    );

    noturn_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b0)) i_noturn_sram_flow (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .din(din_f), .dout(dout_f), .oe(oe_f)
    );

    task automatic add_cmd(input logic e, input logic w, input logic [AW-1:0] a, input string t);
        c_ce[ncmd]  = e;
        c_we[ncmd]  = w;
        c_a[ncmd]   = a;
        c_wd[ncmd]  = DW'((ncmd * 37 + 5) & 255);
        c_tag[ncmd] = t;
        ncmd++;
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Judge the slot of command k on one instance
    task automatic judge(input int k, input logic o, input logic [DW-1:0] d, input string inst);
        if (k < 0 || k >= ncmd || !c_ce[k]) begin
            check(o == 1'b0, "R7", {inst, " idle slot oe"}, int'(o), 0);
        end else if (c_we[k]) begin
            check(o == 1'b0, "R6", {inst, " write slot oe"}, int'(o), 0);
        end else begin
            check(o == 1'b1, inst, "read slot oe", int'(o), 1);
            check(d == c_ex[k], c_tag[k], {inst, " read word"}, int'(d), int'(c_ex[k]));
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        // Phase A: fill every word, then read all (R3)
        for (int a = 0; a < NA; a++) add_cmd(1'b1, 1'b1, AW'(a), "R3");
        for (int a = 0; a < NA; a++) add_cmd(1'b1, 1'b0, AW'(a), "R3");
        // Phase B: write then read same word on adjacent edges (R5)
        for (int a = 0; a < NA; a++) begin
            add_cmd(1'b1, 1'b1, AW'(NA - 1 - a), "R4");
            add_cmd(1'b1, 1'b0, AW'(NA - 1 - a), "R5");
        end
        // Phase C: disabled cycle with we high, then read back (R7)
        for (int a = 0; a < NA; a++) begin
            add_cmd(1'b0, 1'b1, AW'(a), "R7");
            add_cmd(1'b1, 1'b0, AW'(a), "R7");
        end
        // Phase D: dense pseudo-random mix (R4, R8)
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            add_cmd(lfsr[0] | lfsr[1], lfsr[2], lfsr[7:4], (i % 2 == 0) ? "R4" : "R8");
        end
        // Reference: command-order semantics
        for (int a = 0; a < NA; a++) model[a] = '0;
        for (int n = 0; n < ncmd; n++) begin
            c_ex[n] = '0;
            if (c_ce[n] && c_we[n]) model[c_a[n]] = c_wd[n];
            else if (c_ce[n]) c_ex[n] = model[c_a[n]];
        end

        repeat (3) @(negedge clk);
        check(oe_p == 1'b0, "R1", "pipelined oe in reset", int'(oe_p), 0);
        check(oe_f == 1'b0, "R1", "flow oe in reset", int'(oe_f), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(oe_p == 1'b0, "R1", "pipelined oe after reset", int'(oe_p), 0);
        check(oe_f == 1'b0, "R1", "flow oe after reset", int'(oe_f), 0);

        for (int n = 0; n < ncmd + 3; n++) begin
            // Outputs in this cycle belong to slots of n-2 (pipelined) and n-1 (flow)
            judge(n - 2, oe_p, dout_p, "R2 pipelined");
            judge(n - 1, oe_f, dout_f, "R9 flow-through");
            if (n < ncmd) begin
                ce   = c_ce[n];
                we   = c_we[n];
                addr = c_a[n];
            end else begin
                ce   = 1'b0;
                we   = 1'b0;
                addr = '0;
            end
            din_p = (n >= 2 && n - 2 < ncmd && c_ce[n-2] && c_we[n-2]) ? c_wd[n-2] : DW'(8'hA5 ^ n);
            din_f = (n >= 1 && n - 1 < ncmd && c_ce[n-1] && c_we[n-1]) ? c_wd[n-1] : DW'(8'h5A ^ n);
            @(negedge clk);
        end
        done = 1'b1;
        finish_run();
    end

endmodule